// File: doc/BRIEF.md
# Strobe-Driven FIFO with Retransmit

A first-in first-out buffer for 9-bit words whose depth is a parameter (256, 512, 1024, 2048 or 4096 words). A producer stores a word by pulling the active-low write strobe low, and a consumer takes a word by pulling the active-low read strobe low. One clock samples both strobes and turns each high-to-low transition into exactly one access. Empty and Full flags serve as the flow-control signals at both edges: a write that meets Full and a read that meets Empty are dropped, so the caller must watch the flags before it strobes. The read data output carries an enable that models a tri-state pin, on only while the read strobe is low.

A status pin is shared between two uses. In standalone mode it is an active-low Half Full flag. In depth-expansion mode it carries an active-low expansion token that marks the write which filled the last location, so that a following device can take over. An active-low retransmit input, honoured only in standalone mode with both strobes idle high, moves the read pointer back to the oldest word still held, so the stored data can be read again.

Top module: `strb_fifo`

## Requirements
- R1: Words are read in the order they were written. A read access loads the data output register with the oldest unread word, visible after the clock edge that accepts the read. The data output holds its value until the next accepted read.
- R2: An access happens on a clock edge where the strobe is sampled low after it was sampled high on the previous edge. A strobe held low for further edges makes no further access.
- R3: A write edge while Full is ignored: nothing is stored and the write pointer does not move.
- R4: A read edge while Empty is ignored: the read pointer does not move and the data output keeps its value.
- R5: `empty` is 1 when the buffer holds no word and `full` is 1 when it holds DEPTH words. Both follow the edge that changes the occupancy.
- R6: With `expand_mode` = 0, `hf_xo_n` is 0 exactly when the occupancy exceeds DEPTH/2 and 1 otherwise.
- R7: With `expand_mode` = 1, `hf_xo_n` is 0 for the single cycle after an edge that accepts a write without a read while the occupancy was DEPTH-1. At all other times it is 1.
- R8: When `rt_n` = 0, `wr_n` = 1, `rd_n` = 1 and `expand_mode` = 0, the read pointer moves to the oldest retained word. If no more than DEPTH words have been written since reset, this is address 0. Otherwise it is the word written DEPTH writes ago. The write pointer is unchanged and the flags follow the new occupancy.
- R9: `rt_n` = 0 has no effect when `expand_mode` = 1 or when either strobe is low.
- R10: `dout_oe` is 1 exactly while `rd_n` is 0.
- R11: A synchronous reset (`rst_n` = 0) clears both pointers and the data output. It leaves `empty` = 1, `full` = 0 and `hf_xo_n` = 1.
- R12: When read and write edges arrive on the same clock edge, each is judged against the flags from before that edge. When Full, the read is taken and the write is dropped. When Empty, the write is taken and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit |
| expand_mode | input | 1 | 0 = standalone, 1 = depth expansion |
| din | input | 9 | Write data |
| dout | output | 9 | Read data register |
| dout_oe | output | 1 | Read data drive enable |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |
| hf_xo_n | output | 1 | Half Full (standalone) or expansion token (expansion), active low |

## Verification
Every access and every retransmit takes effect on the first rising edge that samples the strobe change. The data register, both flags and the expansion token can therefore be compared one edge after the stimulus. `dout_oe` and the Half Full level depend only on the present strobe and the present occupancy. The bench changes inputs on the falling edge and compares against its reference model on the next falling edge, so each result is read one full edge after it becomes due. Directed sequences hold strobes low, overrun, underrun, retransmit before and after wraparound, and collide reads with writes at both flag boundaries.

// File: rtl/strb_fifo_pkg.sv
package strb_fifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/strb_fall_detect.sv
module strb_fall_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_det
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= lvl_n[i];
    end
    assign fall[i] = prev_q[i] & ~lvl_n[i];
  end
endmodule

// File: rtl/strb_fifo_mem.sv
module strb_fifo_mem
  import strb_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/strb_fifo_ctrl.sv
module strb_fifo_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fall,
  input  logic        rd_fall,
  input  logic        rewind,
  output logic        wr_fire,
  output logic        rd_fire,
  output logic [AW:0] wr_ptr,
  output logic [AW:0] rd_ptr,
  output logic [AW:0] occupancy,
  output logic        over_q,
  output logic        empty,
  output logic        full
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  assign occupancy = wr_ptr - rd_ptr;
  assign empty     = (occupancy == '0);
  assign full      = (occupancy == DEPTH_V);
  assign wr_fire   = wr_fall & ~full & ~rewind;
  assign rd_fire   = rd_fall & ~empty & ~rewind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      over_q <= 1'b0;
    end else begin
      if (wr_fire) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (wr_ptr[AW]) over_q <= 1'b1;
      end
      if (rewind)       rd_ptr <= over_q ? (wr_ptr - DEPTH_V) : '0;
      else if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/strb_fifo.sv
module strb_fifo
  import strb_fifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic              expand_mode,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_oe,
  output logic              empty,
  output logic              full,
  output logic              hf_xo_n
);
  localparam int          AW      = $clog2(DEPTH);
  localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] LAST_V  = (AW+1)'(DEPTH - 1);

  logic [1:0]  falls;
  logic        wr_fall, rd_fall, rewind;
  logic        wr_fire, rd_fire, over_q;
  logic [AW:0] wr_ptr, rd_ptr, occupancy;
  logic        xo_q;

  strb_fall_detect #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_n ({rd_n, wr_n}),
    .fall  (falls)
  );
  assign wr_fall = falls[0];
  assign rd_fall = falls[1];
  assign rewind  = ~rt_n & wr_n & rd_n & ~expand_mode;

  strb_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fall   (wr_fall),
    .rd_fall   (rd_fall),
    .rewind    (rewind),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .occupancy (occupancy),
    .over_q    (over_q),
    .empty     (empty),
    .full      (full)
  );

  strb_fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (din),
    .re    (rd_fire),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (dout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) xo_q <= 1'b1;
    else        xo_q <= ~(wr_fire & ~rd_fire & (occupancy == LAST_V));
  end

  assign hf_xo_n = expand_mode ? xo_q : ~(occupancy > HALF_V);
  assign dout_oe = ~rd_n;
endmodule

// File: rtl/strb_fifo_chk.sv
module strb_fifo_chk #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_n,
  input logic        rd_n,
  input logic        rt_n,
  input logic        expand_mode,
  input logic        empty,
  input logic        full,
  input logic        hf_xo_n,
  input logic        wr_fall,
  input logic        rd_fall,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] rd_ptr,
  input logic        over_q
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !rd_fall) |=> $stable(rd_ptr));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_fall && !rd_fall) |=> (full && $stable(wr_ptr)));

  p_no_underrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_fall) |=> $stable(rd_ptr));

  p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!expand_mode && !rt_n && wr_n && rd_n && !over_q) |=> (rd_ptr == '0));

  p_rt_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expand_mode && !rt_n && rd_n) |=> $stable(rd_ptr));

  p_reset_r11: assert property (@(posedge clk)
    !rst_n |=> (empty && !full && hf_xo_n));
endmodule

bind strb_fifo strb_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_n        (wr_n),
  .rd_n        (rd_n),
  .rt_n        (rt_n),
  .expand_mode (expand_mode),
  .empty       (empty),
  .full        (full),
  .hf_xo_n     (hf_xo_n),
  .wr_fall     (wr_fall),
  .rd_fall     (rd_fall),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .over_q      (over_q)
);

// File: tb/strb_fifo_tb.sv
module strb_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1, expand_mode = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       dout_oe, empty, full, hf_xo_n;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [8:0] m_mem [D];
  int  m_wt, m_rd;
  bit  m_over, m_wprev, m_rprev;
  logic [8:0] e_dout;
  bit  e_empty, e_full, e_hf, e_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  strb_fifo #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .expand_mode(expand_mode), .din(din), .dout(dout), .dout_oe(dout_oe),
    .empty(empty), .full(full), .hf_xo_n(hf_xo_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit flag_hf(input int cnt, input bit mode, input bit xo);
    return mode ? xo : !(cnt > D/2);
  endfunction

  task automatic compare(input string tag);
    chk(dout == e_dout, {"R1 data ", tag}, dout, e_dout);
    chk(empty == e_empty, {"R5 empty ", tag}, empty, e_empty);
    chk(full == e_full, {"R5 full ", tag}, full, e_full);
    chk(hf_xo_n == e_hf, {"R6/R7 hf_xo_n ", tag}, hf_xo_n, e_hf);
    chk(dout_oe == e_oe, {"R10 oe ", tag}, dout_oe, e_oe);
  endtask

  // one sampling clock: drive at falling edge, model the next rising edge, compare at next falling edge
  task automatic step(input bit w, input bit r, input bit t, input bit m, input string tag);
    bit wf, rf, rew, dw, dr, xo;
    int cnt;
    logic [8:0] d;
    d = 9'($urandom);
    wr_n = w; rd_n = r; rt_n = t; expand_mode = m; din = d;
    wf = m_wprev & !w; rf = m_rprev & !r;
    m_wprev = w; m_rprev = r;
    cnt = m_wt - m_rd;
    rew = !m && !t && w && r;
    xo = 1'b1;
    if (rew) begin
      m_rd = m_over ? m_wt - D : 0;   // R8
    end else begin
      dw = wf && cnt < D;             // R3, R12
      dr = rf && cnt > 0;             // R4, R12
      if (dr) begin e_dout = m_mem[m_rd % D]; m_rd++; end
      if (dw) begin
        m_mem[m_wt % D] = d;
        if (m_wt >= D) m_over = 1'b1;
        m_wt++;
      end
      if (dw && !dr && cnt == D-1) xo = 1'b0;   // R7
    end
    cnt = m_wt - m_rd;
    e_empty = (cnt == 0); e_full = (cnt == D);
    e_hf = flag_hf(cnt, m, xo); e_oe = !r;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    m_wt = 0; m_rd = 0; m_over = 0; m_wprev = 1; m_rprev = 1;
    e_dout = '0; e_empty = 1; e_full = 0; e_hf = 1; e_oe = 0;
    repeat (2) @(negedge clk);
    chk(empty == 1'b1, "R11 empty", empty, 1);
    chk(full == 1'b0, "R11 full", full, 0);
    chk(hf_xo_n == 1'b1, "R11 hf", hf_xo_n, 1);
    chk(dout == '0, "R11 dout", dout, 0);
    rst_n = 1'b1;
  endtask

  task automatic pulse_w(input bit m, input string tag);
    step(1, 1, 1, m, tag); step(0, 1, 1, m, tag);
  endtask
  task automatic pulse_r(input bit m, input string tag);
    step(1, 1, 1, m, tag); step(1, 0, 1, m, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R2: strobe held low gives one access
    step(0, 1, 1, 0, "R2"); repeat (4) step(0, 1, 1, 0, "R2");
    chk(m_wt == 1, "R2 single write", m_wt, 1);
    step(1, 0, 1, 0, "R2"); repeat (4) step(1, 0, 1, 0, "R2");
    // R4: reads while empty ignored
    pulse_r(0, "R4"); pulse_r(0, "R4");
    // R12: read+write together while empty
    step(1, 1, 1, 0, "R12"); step(0, 0, 1, 0, "R12");
    chk(empty == 1'b0, "R12 write taken when empty", empty, 0);
    // fill to full, then overrun (R3)
    while (m_wt - m_rd < D) pulse_w(0, "R6");
    chk(full == 1'b1, "R5 full reached", full, 1);
    pulse_w(0, "R3"); pulse_w(0, "R3");
    // R12 at full
    step(1, 1, 1, 0, "R12"); step(0, 0, 1, 0, "R12");
    // R8 retransmit after wraparound, then R9 ignored cases
    step(1, 1, 0, 0, "R8");
    step(1, 1, 0, 1, "R9"); step(0, 1, 0, 0, "R9"); step(1, 0, 0, 0, "R9");
    while (m_wt != m_rd) pulse_r(0, "R1");
    pulse_r(0, "R4");

    // R7 expansion token
    do_reset();
    while (m_wt < D) pulse_w(1, "R7");
    step(1, 1, 1, 1, "R7");
    // R8 retransmit before wraparound
    do_reset();
    repeat (20) pulse_w(0, "R8");
    repeat (7) pulse_r(0, "R8");
    step(1, 1, 0, 0, "R8");
    chk(m_rd == 0, "R8 rewind to zero", m_rd, 0);
    repeat (20) pulse_r(0, "R8");

    // constrained random
    for (int ph = 0; ph < 6; ph++) begin
      int pw = (ph % 3 == 0) ? 70 : (ph % 3 == 1) ? 30 : 50;
      bit md = (ph == 4);
      for (int i = 0; i < 3000; i++) begin
        bit w = ($urandom % 100) >= pw;
        bit r = ($urandom % 100) < pw;
        bit t = ($urandom % 100) >= 4;
        step(w, r, t, md, "rand");
      end
    end
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule